// File: doc/BRIEF.md
# SDRAM Bank Timing Gate

This block stands between the request side of a memory controller and the command pins of a four-bank SDRAM. Each cycle the controller may present one command with a bank and an address. The gate decides whether the command may go to the device now. If it may, the command is passed to registered command pins. If it may not, `req_ready` is held low and the controller keeps the request until it is taken.

Per bank, the gate tracks whether a row is open and how many clocks remain before each kind of follow-up command becomes legal. Every minimum interval is a clock count. The count comes from one of two profiles, chosen by the `cl3` input (CAS latency 3 or 2). A request that is illegal for the current bank state is not stalled: it is consumed, it is not issued, and a one-cycle error pulse marks it. The gate also produces the byte mask that actually applies to the data bus. Read masks take effect two clocks late; write masks take effect at once.

Command code `{ras_n,cas_n,we_n}`: activate 011, read 101, write 100, precharge 010, auto refresh 001, mode register set 000, no-operation 111. Address bit 10 is the all-banks flag on precharge and the auto-precharge flag on write. A distance of N clocks means the later command may be accepted N cycles after the earlier one.

Top module: `sdram_cmd_gate`

## Requirements
- R1: An accepted request appears on `cmd_ras_n/cmd_cas_n/cmd_we_n`, `cmd_ba` and `cmd_addr` one clock after acceptance, with `cmd_cs_n` low. `cmd_ba` value k (00, 01, 10, 11) addresses bank k. In cycles where nothing is issued, `cmd_cs_n` is high. Codes 111 and 110 are issued and change no bank state.
- R2: The following requests are protocol errors: an activate to an open bank, a read or write to a closed bank, and a refresh or mode register set while any bank is open. Each is consumed (ready high) and not issued, and `proto_err` pulses one clock later.
- R3: On the same bank, a read or write needs 3 clocks after its activate at CAS latency 3 and 2 clocks at CAS latency 2.
- R4: On the same bank, a precharge needs 6 clocks (CL3) or 5 clocks (CL2) after the activate, and 2 clocks after the last write.
- R5: On the same bank, an activate needs 3 clocks (CL3) or 2 clocks (CL2) after a precharge, and 9 clocks (CL3) or 7 clocks (CL2) after the previous activate.
- R6: Activates to different banks are at least 2 clocks apart in both profiles.
- R7: A write with address bit 10 high closes its bank. It also requires the R4 activate-to-precharge interval to have passed. The next activate of that bank needs 5 clocks (CL3) or 4 clocks (CL2) after the write. On a read, bit 10 has no effect and the bank stays open.
- R8: A precharge with bit 10 high closes every open bank. With bit 10 low it closes only the addressed bank. A precharge of a closed bank is issued and has no timing effect.
- R9: Refresh and mode register set wait until every bank meets its R5 and R7 activate intervals. After a refresh, the next activate, refresh or mode register set needs 9 clocks (CL3) or 7 clocks (CL2). A mode register set adds no wait.
- R10: A request with `req_cs_n` high is consumed with ready high. It is not issued, it raises no error, and it changes no bank state. Timers keep counting.
- R11: Column commands to an open bank whose R3 interval has passed are accepted on every consecutive clock.
- R12: When `mask_rd` is high, `mask_eff` equals `mask_in` from two clocks earlier. When `mask_rd` is low, it equals the current `mask_in`.
- R13: After reset all banks are closed, `cmd_cs_n` is high, `proto_err` is low and an idle request side sees ready high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cl3 | input | 1 | 1 selects the CAS latency 3 timing profile, 0 the CAS latency 2 profile |
| req_valid | input | 1 | A request is present |
| req_cs_n | input | 1 | Chip select of the request, active low |
| req_cmd | input | 3 | Requested `{ras_n,cas_n,we_n}` code |
| req_ba | input | 2 | Requested bank |
| req_addr | input | 13 | Requested row/column address; bit 10 is the all-bank / auto-precharge flag |
| req_ready | output | 1 | Request consumed this cycle (combinational) |
| mask_in | input | 8 | Byte mask from the controller |
| mask_rd | input | 1 | 1 when the mask refers to read data |
| cmd_cs_n | output | 1 | Chip select to the device |
| cmd_ras_n | output | 1 | Row strobe to the device |
| cmd_cas_n | output | 1 | Column strobe to the device |
| cmd_we_n | output | 1 | Write enable to the device |
| cmd_ba | output | 2 | Bank address to the device |
| cmd_addr | output | 13 | Address to the device |
| proto_err | output | 1 | One-cycle pulse for a rejected illegal request |
| mask_eff | output | 8 | Byte mask effective on the data bus this cycle |

## Verification
`req_ready` is a same-cycle decision. The bench drives a request at the falling edge and samples ready 1 ns later. The command pins and `proto_err` settle one clock after acceptance, so the bench checks them at the next falling edge against the expectation it stored when the request was taken. `mask_eff` is checked in the drive cycle against the current mask for writes, and against a two-deep history for reads. Each interval is measured by counting the attempts a stalled request needs: a command issued at cycle t with a minimum distance N must be taken exactly at t+N.

// File: rtl/sdram_cmd_gate.sv
module sdram_cmd_gate #(
  parameter int BAW     = 2,
  parameter int AW      = 13,
  parameter int MW      = 8,
  parameter int CW      = 4,
  parameter int AP_BIT  = 10,
  parameter int RCD_CL3 = 3,
  parameter int RCD_CL2 = 2,
  parameter int RP_CL3  = 3,
  parameter int RP_CL2  = 2,
  parameter int RAS_CL3 = 6,
  parameter int RAS_CL2 = 5,
  parameter int RC_CL3  = 9,
  parameter int RC_CL2  = 7,
  parameter int DAL_CL3 = 5,
  parameter int DAL_CL2 = 4,
  parameter int RRD     = 2,
  parameter int WRR     = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cl3,
  input  logic           req_valid,
  input  logic           req_cs_n,
  input  logic [2:0]     req_cmd,
  input  logic [BAW-1:0] req_ba,
  input  logic [AW-1:0]  req_addr,
  output logic           req_ready,
  input  logic [MW-1:0]  mask_in,
  input  logic           mask_rd,
  output logic           cmd_cs_n,
  output logic           cmd_ras_n,
  output logic           cmd_cas_n,
  output logic           cmd_we_n,
  output logic [BAW-1:0] cmd_ba,
  output logic [AW-1:0]  cmd_addr,
  output logic           proto_err,
  output logic [MW-1:0]  mask_eff
);
  localparam int NB = 1 << BAW;
  localparam logic [2:0] C_MRS = 3'b000, C_REF = 3'b001, C_PRE = 3'b010,
                         C_ACT = 3'b011, C_WR  = 3'b100, C_RD  = 3'b101;
  localparam logic [CW-1:0] ONE = CW'(1);
  localparam logic [CW-1:0] SAT = '1;

  wire [CW-1:0] t_rcd = cl3 ? CW'(RCD_CL3) : CW'(RCD_CL2);
  wire [CW-1:0] t_rp  = cl3 ? CW'(RP_CL3)  : CW'(RP_CL2);
  wire [CW-1:0] t_ras = cl3 ? CW'(RAS_CL3) : CW'(RAS_CL2);
  wire [CW-1:0] t_rc  = cl3 ? CW'(RC_CL3)  : CW'(RC_CL2);
  wire [CW-1:0] t_dal = cl3 ? CW'(DAL_CL3) : CW'(DAL_CL2);
  wire [CW-1:0] t_rrd = CW'(RRD);
  wire [CW-1:0] t_wr  = CW'(WRR);

  logic [NB-1:0] open_q;
  logic [CW-1:0] rcd_c [NB];
  logic [CW-1:0] ras_c [NB];
  logic [CW-1:0] wr_c  [NB];
  logic [CW-1:0] aa_c  [NB];
  logic [CW-1:0] rrd_c, rfc_c;
  logic [MW-1:0] m1_q, m2_q;

  function automatic logic [CW-1:0] dn(input logic [CW-1:0] v);
    return (v == '0) ? v : v - ONE;
  endfunction

  function automatic logic [CW-1:0] ld(input logic [CW-1:0] cur, input logic [CW-1:0] val);
    logic [CW-1:0] d;
    d = dn(cur);
    return (d > val) ? d : val;
  endfunction

  wire sel    = req_valid & ~req_cs_n;
  wire ap     = req_addr[AP_BIT];
  wire is_act = req_cmd == C_ACT;
  wire is_rd  = req_cmd == C_RD;
  wire is_wr  = req_cmd == C_WR;
  wire is_pre = req_cmd == C_PRE;
  wire is_ref = req_cmd == C_REF;
  wire is_mrs = req_cmd == C_MRS;
  wire bopen  = open_q[req_ba];

  logic all_idle, pre_ok, tim_ok;
  always_comb begin
    all_idle = (rfc_c == '0);
    pre_ok   = 1'b1;
    for (int b = 0; b < NB; b++) begin
      if (aa_c[b] != '0) all_idle = 1'b0;
      if (open_q[b] && (ap || req_ba == BAW'(b)) && (ras_c[b] != '0 || wr_c[b] != '0))
        pre_ok = 1'b0;
    end
  end

  always_comb begin
    case (req_cmd)
      C_ACT:        tim_ok = (aa_c[req_ba] == '0) && (rrd_c == '0) && (rfc_c == '0);
      C_RD:         tim_ok = (rcd_c[req_ba] == '0);
      C_WR:         tim_ok = (rcd_c[req_ba] == '0) && (!ap || ras_c[req_ba] == '0);
      C_PRE:        tim_ok = pre_ok;
      C_REF, C_MRS: tim_ok = all_idle;
      default:      tim_ok = 1'b1;
    endcase
  end

  wire err = sel & ((is_act & bopen) | ((is_rd | is_wr) & ~bopen) | ((is_ref | is_mrs) & (|open_q)));
  wire go  = sel & ~err & tim_ok;
  assign req_ready = ~req_valid | req_cs_n | err | tim_ok;

  logic [NB-1:0] act_v, wr_v, pcl_v, wrap_v;
  always_comb begin
    for (int b = 0; b < NB; b++) begin
      act_v[b]  = go && is_act && req_ba == BAW'(b);
      wr_v[b]   = go && is_wr && req_ba == BAW'(b);
      wrap_v[b] = wr_v[b] && ap;
      pcl_v[b]  = go && is_pre && open_q[b] && (ap || req_ba == BAW'(b));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q <= '0;
      rrd_c  <= '0;
      rfc_c  <= '0;
      for (int b = 0; b < NB; b++) begin
        rcd_c[b] <= '0;
        ras_c[b] <= '0;
        wr_c[b]  <= '0;
        aa_c[b]  <= '0;
      end
    end else begin
      rrd_c <= (go && is_act) ? t_rrd - ONE : dn(rrd_c);
      rfc_c <= (go && is_ref) ? t_rc - ONE : dn(rfc_c);
      for (int b = 0; b < NB; b++) begin
        wr_c[b] <= wr_v[b] ? t_wr - ONE : dn(wr_c[b]);
        if (act_v[b]) begin
          open_q[b] <= 1'b1;
          rcd_c[b]  <= t_rcd - ONE;
          ras_c[b]  <= t_ras - ONE;
          aa_c[b]   <= t_rc - ONE;
        end else begin
          rcd_c[b] <= dn(rcd_c[b]);
          ras_c[b] <= dn(ras_c[b]);
          if (pcl_v[b])       aa_c[b] <= ld(aa_c[b], t_rp - ONE);
          else if (wrap_v[b]) aa_c[b] <= ld(aa_c[b], t_dal - ONE);
          else                aa_c[b] <= dn(aa_c[b]);
          if (pcl_v[b] || wrap_v[b]) open_q[b] <= 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_cs_n  <= 1'b1;
      {cmd_ras_n, cmd_cas_n, cmd_we_n} <= 3'b111;
      cmd_ba    <= '0;
      cmd_addr  <= '0;
      proto_err <= 1'b0;
      m1_q      <= '0;
      m2_q      <= '0;
    end else begin
      cmd_cs_n  <= ~go;
      {cmd_ras_n, cmd_cas_n, cmd_we_n} <= go ? req_cmd : 3'b111;
      cmd_ba    <= go ? req_ba : '0;
      cmd_addr  <= go ? req_addr : '0;
      proto_err <= err;
      m1_q      <= mask_in;
      m2_q      <= m1_q;
    end
  end

  assign mask_eff = mask_rd ? m2_q : mask_in;

  // Pin-level spacing monitors for the assertions below
  wire [2:0] out_code = {cmd_ras_n, cmd_cas_n, cmd_we_n};
  wire out_act = ~cmd_cs_n && out_code == C_ACT;
  wire out_col = ~cmd_cs_n && (out_code == C_RD || out_code == C_WR);
  logic [CW-1:0] gap_q [NB];
  logic [CW-1:0] gap_any;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_any <= SAT;
      for (int b = 0; b < NB; b++) gap_q[b] <= SAT;
    end else begin
      gap_any <= out_act ? ONE : (gap_any == SAT ? SAT : gap_any + ONE);
      for (int b = 0; b < NB; b++)
        gap_q[b] <= (out_act && cmd_ba == BAW'(b)) ? ONE : (gap_q[b] == SAT ? SAT : gap_q[b] + ONE);
    end
  end

  assert_rcd_spacing_R3: assert property (@(posedge clk) disable iff (!rst_n)
    out_col |-> gap_q[cmd_ba] >= t_rcd) else $error("column command too close to activate");

  assert_act_spacing_R5: assert property (@(posedge clk) disable iff (!rst_n)
    out_act |-> gap_q[cmd_ba] >= t_rc) else $error("same-bank activates too close");

  assert_rrd_spacing_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_act |-> gap_any >= t_rrd) else $error("activates too close");

  assert_err_not_issued_R2: assert property (@(posedge clk) disable iff (!rst_n)
    proto_err |-> cmd_cs_n) else $error("rejected request reached the pins");

  assert_deselect_inert_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_cs_n) |=> (cmd_cs_n && open_q == $past(open_q))) else $error("deselected request had an effect");
endmodule

// File: tb/sdram_cmd_gate_test.sv
`timescale 1ns/1ps
module sdram_cmd_gate_test;
  localparam logic [2:0] ACT = 3'b011, RD = 3'b101, WR = 3'b100, PRE = 3'b010,
                         REF = 3'b001, MRS = 3'b000, NOP = 3'b111;

  logic clk = 0, rst_n = 0, cl3 = 1, req_valid = 0, req_cs_n = 0, mask_rd = 0;
  logic [2:0] req_cmd = NOP;
  logic [1:0] req_ba = 0;
  logic [12:0] req_addr = 0;
  logic [7:0] mask_in = 0;
  wire req_ready, cmd_cs_n, cmd_ras_n, cmd_cas_n, cmd_we_n, proto_err;
  wire [1:0] cmd_ba;
  wire [12:0] cmd_addr;
  wire [7:0] mask_eff;

  sdram_cmd_gate uut (
    .clk(clk), .rst_n(rst_n), .cl3(cl3), .req_valid(req_valid), .req_cs_n(req_cs_n),
    .req_cmd(req_cmd), .req_ba(req_ba), .req_addr(req_addr), .req_ready(req_ready),
    .mask_in(mask_in), .mask_rd(mask_rd), .cmd_cs_n(cmd_cs_n), .cmd_ras_n(cmd_ras_n),
    .cmd_cas_n(cmd_cas_n), .cmd_we_n(cmd_we_n), .cmd_ba(cmd_ba), .cmd_addr(cmd_addr),
    .proto_err(proto_err), .mask_eff(mask_eff));

  always #2.5 clk = ~clk;

  int checks = 0, errors = 0, now = 0, t_any, t_ref;
  int t_act[4], t_pre[4], t_wr[4], t_dal[4];
  bit mopen[4];
  bit exp_issue, exp_perr, last_perr, done = 0;
  logic [2:0] exp_cmd;
  logic [1:0] exp_ba;
  logic [12:0] exp_addr;
  logic [7:0] h1, h2;

  function automatic int d_rcd(); return cl3 ? 3 : 2; endfunction
  function automatic int d_rp();  return cl3 ? 3 : 2; endfunction
  function automatic int d_ras(); return cl3 ? 6 : 5; endfunction
  function automatic int d_rc();  return cl3 ? 9 : 7; endfunction
  function automatic int d_dal(); return cl3 ? 5 : 4; endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", tag, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    now = 0; t_any = -100; t_ref = -100;
    for (int k = 0; k < 4; k++) begin
      t_act[k] = -100; t_pre[k] = -100; t_wr[k] = -100; t_dal[k] = -100; mopen[k] = 0;
    end
    exp_issue = 0; exp_perr = 0; h1 = 0; h2 = 0;
  endtask

  task automatic do_cycle(input bit v, input bit csn, input logic [2:0] c,
                          input logic [1:0] b, input logic [12:0] a, output bit rdy);
    bit sel, err, ok;
    string tag;
    logic [7:0] me;
    @(negedge clk);
    last_perr = proto_err;
    chk(cmd_cs_n == !exp_issue, "R1 chip select", cmd_cs_n, !exp_issue);
    if (exp_issue) begin
      chk({cmd_ras_n, cmd_cas_n, cmd_we_n} == exp_cmd, "R1 command code",
          {cmd_ras_n, cmd_cas_n, cmd_we_n}, exp_cmd);
      chk(cmd_ba == exp_ba, "R1 bank", cmd_ba, exp_ba);
      chk(cmd_addr == exp_addr, "R1 address", cmd_addr, exp_addr);
    end
    chk(proto_err == exp_perr, "R2 error pulse", proto_err, exp_perr);
    req_valid = v; req_cs_n = csn; req_cmd = c; req_ba = b; req_addr = a;
    mask_in = 8'($urandom); mask_rd = 1'($urandom);
    #1;
    sel = v && !csn; err = 0; ok = 1; tag = "R1";
    case (c)
      ACT: begin
        tag = "R5"; err = mopen[b];
        ok = now - t_act[b] >= d_rc() && now - t_pre[b] >= d_rp() && now - t_dal[b] >= d_dal()
             && now - t_any >= 2 && now - t_ref >= d_rc();
      end
      RD: begin tag = "R3"; err = !mopen[b]; ok = now - t_act[b] >= d_rcd(); end
      WR: begin
        tag = "R7"; err = !mopen[b];
        ok = now - t_act[b] >= d_rcd() && (!a[10] || now - t_act[b] >= d_ras());
      end
      PRE: begin
        tag = "R8";
        for (int k = 0; k < 4; k++)
          if ((a[10] || k == b) && mopen[k] && (now - t_act[k] < d_ras() || now - t_wr[k] < 2)) ok = 0;
      end
      REF, MRS: begin
        tag = "R9"; err = mopen[0] | mopen[1] | mopen[2] | mopen[3];
        ok = now - t_ref >= d_rc();
        for (int k = 0; k < 4; k++)
          if (now - t_act[k] < d_rc() || now - t_pre[k] < d_rp() || now - t_dal[k] < d_dal()) ok = 0;
      end
      default: ok = 1;
    endcase
    err = err && sel;
    if (v && csn) tag = "R10";
    if (err) tag = "R2";
    rdy = req_ready;
    chk(req_ready == (!v || csn || err || ok), tag, req_ready, (!v || csn || err || ok));
    me = mask_rd ? h2 : mask_in;
    chk(mask_eff == me, "R12 mask timing", mask_eff, me);
    h2 = h1; h1 = mask_in;
    exp_issue = sel && !err && ok; exp_perr = err;
    exp_cmd = c; exp_ba = b; exp_addr = a;
    if (exp_issue) begin
      case (c)
        ACT: begin mopen[b] = 1; t_act[b] = now; t_any = now; end
        WR:  begin t_wr[b] = now; if (a[10]) begin mopen[b] = 0; t_dal[b] = now; end end
        PRE: for (int k = 0; k < 4; k++)
               if ((a[10] || k == b) && mopen[k]) begin mopen[k] = 0; t_pre[k] = now; end
        REF: t_ref = now;
        default: ;
      endcase
    end
    now++;
  endtask

  task automatic idle(input int k);
    bit r;
    repeat (k) do_cycle(0, 0, NOP, 0, 0, r);
  endtask

  task automatic try_cmd(input logic [2:0] c, input logic [1:0] b, input logic [12:0] a, output int n);
    bit r;
    n = 0;
    do begin do_cycle(1, 0, c, b, a, r); n++; end while (!r && n < 40);
  endtask

  task automatic close_all();
    int n;
    idle(12); try_cmd(PRE, 0, 13'h400, n); idle(12);
  endtask

  task automatic do_reset(input bit p);
    req_valid = 0; mask_in = 0; rst_n = 0; cl3 = p;
    repeat (3) @(negedge clk);
    rst_n = 1;
    model_reset();
    #1;
    chk(cmd_cs_n == 1, "R13 pins deselected", cmd_cs_n, 1);
    chk(proto_err == 0, "R13 no error", proto_err, 0);
    chk(req_ready == 1, "R13 ready when idle", req_ready, 1);
  endtask

  task automatic directed();
    int n;
    bit r;
    try_cmd(RD, 0, 0, n); idle(1);
    chk(last_perr == 1, "R13 banks closed after reset", last_perr, 1);
    // R3 and R11
    try_cmd(ACT, 0, 13'h012, n); chk(n == 1, "R3 activate", n, 1);
    try_cmd(RD, 0, 13'h004, n);  chk(n == d_rcd(), "R3 activate to read", n, d_rcd());
    try_cmd(RD, 0, 13'h005, n);  chk(n == 1, "R11 read back to back", n, 1);
    try_cmd(WR, 0, 13'h006, n);  chk(n == 1, "R11 write after read", n, 1);
    close_all();
    // R4 activate to precharge
    try_cmd(ACT, 1, 0, n);
    try_cmd(PRE, 1, 0, n); chk(n == d_ras(), "R4 activate to precharge", n, d_ras());
    close_all();
    // R5 precharge to activate
    try_cmd(ACT, 2, 0, n); idle(12);
    try_cmd(PRE, 2, 0, n); chk(n == 1, "R5 precharge", n, 1);
    try_cmd(ACT, 2, 0, n); chk(n == d_rp(), "R5 precharge to activate", n, d_rp());
    close_all();
    // R4 write recovery
    try_cmd(ACT, 0, 0, n); idle(12);
    try_cmd(WR, 0, 0, n);
    try_cmd(PRE, 0, 0, n); chk(n == 2, "R4 write to precharge", n, 2);
    close_all();
    // R7 write with auto-precharge
    try_cmd(ACT, 1, 0, n); idle(12);
    try_cmd(WR, 1, 13'h400, n); chk(n == 1, "R7 auto-precharge write", n, 1);
    try_cmd(RD, 1, 0, n); idle(1);
    chk(last_perr == 1, "R7 bank closed by write", last_perr, 1);
    try_cmd(ACT, 1, 0, n); chk(n == d_dal() - 2, "R7 write to activate", n, d_dal() - 2);
    close_all();
    try_cmd(ACT, 2, 0, n); idle(12);
    try_cmd(RD, 2, 13'h400, n);
    try_cmd(RD, 2, 0, n); idle(1);
    chk(last_perr == 0, "R7 bit 10 ignored on read", last_perr, 0);
    close_all();
    // R6 and R8
    try_cmd(ACT, 0, 0, n);
    try_cmd(ACT, 1, 0, n); chk(n == 2, "R6 activate other bank", n, 2);
    idle(12);
    try_cmd(PRE, 0, 0, n);
    try_cmd(RD, 1, 0, n); idle(1);
    chk(last_perr == 0, "R8 single precharge keeps others", last_perr, 0);
    try_cmd(RD, 0, 0, n); idle(1);
    chk(last_perr == 1, "R8 single precharge closes bank", last_perr, 1);
    try_cmd(PRE, 3, 0, n); chk(n == 1, "R8 precharge of closed bank", n, 1);
    try_cmd(PRE, 2, 13'h400, n); chk(n == 1, "R8 precharge all", n, 1);
    try_cmd(RD, 1, 0, n); idle(1);
    chk(last_perr == 1, "R8 precharge all closes bank", last_perr, 1);
    close_all();
    // R9 refresh
    try_cmd(REF, 0, 0, n); chk(n == 1, "R9 refresh", n, 1);
    try_cmd(ACT, 0, 0, n); chk(n == d_rc(), "R9 refresh to activate", n, d_rc());
    idle(12);
    try_cmd(REF, 0, 0, n); idle(1);
    chk(last_perr == 1, "R9 refresh with open bank", last_perr, 1);
    close_all();
    // R10 deselect
    try_cmd(ACT, 0, 0, n);
    do_cycle(1, 1, ACT, 0, 0, r); chk(r == 1, "R10 deselect consumed", r, 1);
    idle(1);
    chk(last_perr == 0, "R10 deselect raises no error", last_perr, 0);
    do_cycle(1, 1, ACT, 3, 0, r); idle(12);
    try_cmd(RD, 3, 0, n); idle(1);
    chk(last_perr == 1, "R10 deselect opened nothing", last_perr, 1);
    close_all();
  endtask

  task automatic rand_run(input int cycles);
    bit r;
    logic [2:0] c;
    bit v;
    for (int i = 0; i < cycles; i++) begin
      int s = $urandom % 16;
      v = 1;
      if (s < 4) c = ACT; else if (s < 7) c = RD; else if (s < 9) c = WR;
      else if (s < 11) c = PRE; else if (s == 11) c = REF; else if (s == 12) c = MRS;
      else if (s == 13) c = NOP; else if (s == 14) c = 3'b110; else begin c = NOP; v = 0; end
      do_cycle(v, ($urandom % 10) == 0, c, 2'($urandom),
               {2'($urandom), ($urandom % 4) == 0, 10'($urandom)}, r);
    end
  endtask

  initial begin
    void'($urandom(32'd7351));
    do_reset(1); directed(); rand_run(2500);
    do_reset(0); directed(); rand_run(2500);
    idle(1);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule